// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath element that takes two operands of a configurable width and returns one result in the same cycle. A four-bit select plus a carry input picks one of fourteen functions. There are eight arithmetic functions, four bitwise logic functions and two single-position shifts of the first operand. The arithmetic functions all run through one shared adder. A small multiplexer in front of the adder decides what the adder sees as its second input: the second operand, its complement, all zeros or all ones. The carry input then adds one more to the sum.

The upper two select bits choose the unit that drives the result: arithmetic, logic, right shift or left shift. The lower two select bits are shared by the arithmetic and logic units. Besides the result, the block reports the carry out of the top bit and a two's-complement overflow flag. Both flags are meaningful only for arithmetic functions. In every other mode they are held low. The width parameter `W` defaults to 8.

Top module: `arith_logic_shift_unit`

## Requirements
- R1: With sel = 4'b0000 and cin = 0, y = (a + b) mod 2^W and cout is the carry out of bit W-1.
- R2: With sel = 4'b0000 and cin = 1, y = (a + b + 1) mod 2^W, with cout as the carry out of bit W-1.
- R3: With sel = 4'b0001, y = (a + ~b + cin) mod 2^W. With cin = 1 this is a - b, and cout = 1 exactly when a >= b as unsigned numbers.
- R4: With sel = 4'b0010, y = a when cin = 0 and y = a + 1 when cin = 1. cout = 1 only when a + 1 wraps to zero. The b input has no effect.
- R5: With sel = 4'b0011, y = a - 1 when cin = 0, with cout = 0 only for a = 0. With cin = 1, y = a and cout = 1. The b input has no effect.
- R6: In arithmetic mode (sel[3:2] = 2'b00), ovf = 1 exactly when the adder's two's-complement result is out of range. That is the XOR of the carry into and the carry out of bit W-1.
- R7: With sel[3:2] = 2'b01, y is chosen by sel[1:0]: 00 gives a AND b, 01 gives a OR b, 10 gives a XOR b, and 11 gives NOT a. cin has no effect.
- R8: With sel[3:2] = 2'b10, y is a shifted right by one with a 0 entering bit W-1. sel[1:0], cin and b have no effect.
- R9: With sel[3:2] = 2'b11, y is a shifted left by one with a 0 entering bit 0. sel[1:0], cin and b have no effect.
- R10: Whenever sel[3:2] is not 2'b00, cout = 0 and ovf = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand; the only source for the shifts and for transfer, increment and decrement |
| b_i | input | W | Second operand |
| sel_i | input | 4 | Function select: [3:2] picks the unit, [1:0] picks the function inside the arithmetic or logic unit |
| cin_i | input | 1 | Carry input to the adder |
| y_o | output | W | Result |
| cout_o | output | 1 | Carry out of the top bit in arithmetic mode, else 0 |
| ovf_o | output | 1 | Signed overflow in arithmetic mode, else 0 |

## Verification
The bench targets each edge of the carry and overflow behaviour:
- Signed overflow is exercised in both directions: positive plus positive giving a negative result, and negative plus negative giving a positive one. A design that took overflow from the carry out alone would flag the wrong cases.
- Increment of all ones and of the largest positive value are both applied. Decrement of zero and of the most negative value are also applied. These expose a mistake in the complement or constant operand selection, or a carry flag with the wrong sense.
- For subtraction, the carry out is checked as the no-borrow indication. Both a >= b and a < b are tested.
- The shifts are checked for the bit that is shifted in. A design that rotated the end bit back in, or shifted the wrong way, would show it there.
- Non-arithmetic modes are driven with operands that would produce a carry and an overflow if they went through the adder. A design that leaked adder flags into those modes would be caught.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Unit chosen by sel[3:2]
    typedef enum logic [1:0] {
        UNIT_ARITH = 2'b00,
        UNIT_LOGIC = 2'b01,
        UNIT_SHR   = 2'b10,
        UNIT_SHL   = 2'b11
    } unit_e;

    // Second adder input chosen by sel[1:0]
    typedef enum logic [1:0] {
        OPND_B    = 2'b00,
        OPND_NOTB = 2'b01,
        OPND_ZERO = 2'b10,
        OPND_ONES = 2'b11
    } opnd_e;

    // Bitwise function chosen by sel[1:0]
    typedef enum logic [1:0] {
        LOG_AND  = 2'b00,
        LOG_OR   = 2'b01,
        LOG_XOR  = 2'b10,
        LOG_NOTA = 2'b11
    } logop_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{carry: 1'b0, ovf: 1'b0};

    function automatic unit_e unit_of(input logic [3:0] sel);
        return unit_e'(sel[3:2]);
    endfunction

endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] b_i,
    input  opnd_e        pick_i,
    output logic [W-1:0] x_o
);
    always_comb begin
        unique case (pick_i)
            OPND_B:    x_o = b_i;
            OPND_NOTB: x_o = ~b_i;
            OPND_ZERO: x_o = '0;
            default:   x_o = '1;
        endcase
    end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] x_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output flags_t       flags_o
);
    localparam int NC = W + 1;

    logic [NC-1:0] c;
    assign c[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = a_i[i] ^ x_i[i] ^ c[i];
        assign c[i+1]   = (a_i[i] & x_i[i]) | (c[i] & (a_i[i] ^ x_i[i]));
    end

    assign flags_o.carry = c[W];
    assign flags_o.ovf   = c[W] ^ c[W-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logop_e       op_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            LOG_AND: y_o = a_i & b_i;
            LOG_OR:  y_o = a_i | b_i;
            LOG_XOR: y_o = a_i ^ b_i;
            default: y_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] shr_o,
    output logic [W-1:0] shl_o
);
    assign shr_o = {1'b0, a_i[W-1:1]};
    assign shl_o = {a_i[W-2:0], 1'b0};
endmodule

// File: rtl/arith_logic_shift_unit.sv
module arith_logic_shift_unit
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   sel_i,
    input  logic         cin_i,
    output logic [W-1:0] y_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] x;
    logic [W-1:0] sum;
    logic [W-1:0] lres;
    logic [W-1:0] shr;
    logic [W-1:0] shl;
    flags_t       aflags;
    flags_t       oflags;
    unit_e        unit;

    assign unit = unit_of(sel_i);

    alu_operand_mux #(.W(W)) u_opmux (
        .b_i    (b_i),
        .pick_i (opnd_e'(sel_i[1:0])),
        .x_o    (x)
    );

    alu_ripple_adder #(.W(W)) u_adder (
        .a_i     (a_i),
        .x_i     (x),
        .cin_i   (cin_i),
        .sum_o   (sum),
        .flags_o (aflags)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a_i  (a_i),
        .b_i  (b_i),
        .op_i (logop_e'(sel_i[1:0])),
        .y_o  (lres)
    );

    alu_shifter #(.W(W)) u_shift (
        .a_i   (a_i),
        .shr_o (shr),
        .shl_o (shl)
    );

    always_comb begin
        oflags = FLAGS_CLEAR;
        unique case (unit)
            UNIT_ARITH: begin
                y_o    = sum;
                oflags = aflags;
            end
            UNIT_LOGIC: y_o = lres;
            UNIT_SHR:   y_o = shr;
            default:    y_o = shl;
        endcase
    end

    assign cout_o = oflags.carry;
    assign ovf_o  = oflags.ovf;
endmodule

// File: rtl/alu_props.sv
module alu_props #(
    parameter int W = 8
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   sel_i,
    input logic         cin_i,
    input logic [W-1:0] y_o,
    input logic         cout_o,
    input logic         ovf_o
);
    logic [W-1:0] ref_x;
    logic [W:0]   ref_sum;

    always_comb begin
        case (sel_i[1:0])
            2'b00:   ref_x = b_i;
            2'b01:   ref_x = ~b_i;
            2'b10:   ref_x = '0;
            default: ref_x = '1;
        endcase
        ref_sum = {1'b0, a_i} + {1'b0, ref_x} + {{W{1'b0}}, cin_i};
    end

    always_comb begin
        // R1 R2 R3 R4 R5: result and carry equal the wide sum
        if (sel_i[3:2] == 2'b00)
            assert_arith_sum_R1: assert ({cout_o, y_o} == ref_sum)
                else $error("arith sum mismatch");
        // R6: overflow when operand signs agree and result sign differs
        if (sel_i[3:2] == 2'b00)
            assert_signed_ovf_R6: assert (ovf_o ==
                ((a_i[W-1] == ref_x[W-1]) && (y_o[W-1] != a_i[W-1])))
                else $error("overflow flag mismatch");
        // R10: flags quiet outside arithmetic
        if (sel_i[3:2] != 2'b00)
            assert_flags_quiet_R10: assert (!cout_o && !ovf_o)
                else $error("flags set outside arithmetic");
        // R8: right shift fills with zero
        if (sel_i[3:2] == 2'b10)
            assert_shr_fill_R8: assert (y_o == {1'b0, a_i[W-1:1]})
                else $error("right shift mismatch");
        // R9: left shift fills with zero
        if (sel_i[3:2] == 2'b11)
            assert_shl_fill_R9: assert (y_o == {a_i[W-2:0], 1'b0})
                else $error("left shift mismatch");
        // R7: complement mode ignores b
        if (sel_i == 4'b0111)
            assert_not_a_R7: assert ((y_o ^ a_i) == '1)
                else $error("complement mismatch");
    end
endmodule

bind arith_logic_shift_unit alu_props #(.W(W)) u_props (.*);

// File: tb/test_arith_logic_shift_unit.sv
module test_arith_logic_shift_unit;
    localparam int W = 8;
    localparam int NV = 22;

    typedef struct packed {
        logic [3:0]   sel;
        logic         cin;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] y;
        logic         c;
        logic         v;
        logic [3:0]   req;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        {4'b0000, 1'b0, 8'hD2, 8'h6D, 8'h3F, 1'b1, 1'b0, 4'd1},  // R1 carry out
        {4'b0000, 1'b0, 8'h3F, 8'h64, 8'hA3, 1'b0, 1'b1, 4'd6},  // R6 pos+pos
        {4'b0000, 1'b0, 8'hC1, 8'h9C, 8'h5D, 1'b1, 1'b1, 4'd6},  // R6 neg+neg
        {4'b0000, 1'b1, 8'h10, 8'h20, 8'h31, 1'b0, 1'b0, 4'd2},  // R2
        {4'b0001, 1'b0, 8'h50, 8'h10, 8'h3F, 1'b1, 1'b0, 4'd3},  // R3 a+~b
        {4'b0001, 1'b1, 8'h50, 8'h10, 8'h40, 1'b1, 1'b0, 4'd3},  // R3 a>=b
        {4'b0001, 1'b1, 8'h10, 8'h50, 8'hC0, 1'b0, 1'b0, 4'd3},  // R3 a<b
        {4'b0001, 1'b1, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1, 4'd6},  // R6 sub ovf
        {4'b0010, 1'b0, 8'hA5, 8'hFF, 8'hA5, 1'b0, 1'b0, 4'd4},  // R4 transfer
        {4'b0010, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 4'd4},  // R4 wrap
        {4'b0010, 1'b1, 8'h7F, 8'hFF, 8'h80, 1'b0, 1'b1, 4'd4},  // R4 inc ovf
        {4'b0011, 1'b0, 8'h00, 8'h12, 8'hFF, 1'b0, 1'b0, 4'd5},  // R5 dec zero
        {4'b0011, 1'b0, 8'h80, 8'h00, 8'h7F, 1'b1, 1'b1, 4'd5},  // R5 dec ovf
        {4'b0011, 1'b1, 8'h5A, 8'h33, 8'h5A, 1'b1, 1'b0, 4'd5},  // R5 transfer
        {4'b0100, 1'b1, 8'hCA, 8'h5C, 8'h48, 1'b0, 1'b0, 4'd7},  // R7 AND
        {4'b0101, 1'b0, 8'hCA, 8'h5C, 8'hDE, 1'b0, 1'b0, 4'd7},  // R7 OR
        {4'b0110, 1'b1, 8'hCA, 8'h5C, 8'h96, 1'b0, 1'b0, 4'd7},  // R7 XOR
        {4'b0111, 1'b0, 8'hCA, 8'h5C, 8'h35, 1'b0, 1'b0, 4'd7},  // R7 NOT a
        {4'b1000, 1'b1, 8'h81, 8'hFF, 8'h40, 1'b0, 1'b0, 4'd8},  // R8
        {4'b1100, 1'b0, 8'h81, 8'hFF, 8'h02, 1'b0, 1'b0, 4'd9},  // R9
        {4'b1011, 1'b1, 8'hFF, 8'hFF, 8'h7F, 1'b0, 1'b0, 4'd8},  // R8 R10
        {4'b1111, 1'b1, 8'hFF, 8'hFF, 8'hFE, 1'b0, 1'b0, 4'd9}   // R9 R10
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b, y;
    logic [3:0]   sel;
    logic         cin, cout, ovf;
    int           checks = 0;
    int           failures = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    arith_logic_shift_unit #(.W(W)) i_arith_logic_shift_unit (
        .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin),
        .y_o(y), .cout_o(cout), .ovf_o(ovf)
    );

    task automatic drive(input logic [3:0] s, input logic c, input logic [W-1:0] av, input logic [W-1:0] bv);
        @(posedge clk);
        sel = s; cin = c; a = av; b = bv;
        @(negedge clk);
    endtask

    task automatic expect3(input string tag, input logic [W-1:0] ey, input logic ec, input logic ev);
        checks++;
        if (y !== ey || cout !== ec || ovf !== ev) begin
            failures++;
            $display("FAIL %s sel=%b cin=%b a=%h b=%h: got y=%h c=%b v=%b expected y=%h c=%b v=%b",
                     tag, sel, cin, a, b, y, cout, ovf, ey, ec, ev);
        end
    endtask

    initial begin
        sel = '0; cin = 1'b0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect3("R1 idle zero", 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].sel, VEC[i].cin, VEC[i].a, VEC[i].b);
            expect3($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].y, VEC[i].c, VEC[i].v);
        end

        // R3 R6: subtraction sweep against integer reference
        for (int ai = 0; ai < 256; ai += 23) begin
            for (int bi = 0; bi < 256; bi += 37) begin
                int sa, sb, d;
                sa = (ai > 127) ? ai - 256 : ai;
                sb = (bi > 127) ? bi - 256 : bi;
                d  = sa - sb;
                drive(4'b0001, 1'b1, ai[W-1:0], bi[W-1:0]);
                expect3("R3 R6 sub sweep", W'(ai - bi), ai >= bi, (d > 127) || (d < -128));
            end
        end

        // R1 R6: addition sweep against integer reference
        for (int ai = 5; ai < 256; ai += 29) begin
            for (int bi = 3; bi < 256; bi += 41) begin
                int sa, sb, s;
                sa = (ai > 127) ? ai - 256 : ai;
                sb = (bi > 127) ? bi - 256 : bi;
                s  = sa + sb;
                drive(4'b0000, 1'b0, ai[W-1:0], bi[W-1:0]);
                expect3("R1 R6 add sweep", W'(ai + bi), (ai + bi) > 255, (s > 127) || (s < -128));
            end
        end

        // R10: logic/shift with operands that would carry and overflow
        drive(4'b0100, 1'b1, 8'hC1, 8'h9C);
        expect3("R10 logic flags", 8'h80, 1'b0, 1'b0);
        drive(4'b1001, 1'b1, 8'hFF, 8'hFF);
        expect3("R10 shr flags", 8'h7F, 1'b0, 1'b0);

        // R4 R5: b must not matter
        drive(4'b0010, 1'b0, 8'h3C, 8'hA5);
        expect3("R4 b ignored", 8'h3C, 1'b0, 1'b0);
        drive(4'b0011, 1'b0, 8'h3C, 8'h00);
        expect3("R5 b ignored", 8'h3B, 1'b1, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule